// File: doc/BRIEF.md
# Sparse Row Index Run Counter

This block turns a stream of packed sparse-matrix coordinates into compressed-row metadata. Each input beat carries one non-zero element's position: a row index in the upper field and a column index in the lower field. Elements arrive in row-major order. The block keeps the row index of the previously accepted element. While the row stays the same, it counts. When the row changes, it emits the finished count. Every column index goes into a column FIFO. Every finished per-row count goes into a row-count FIFO. A downstream multiply-accumulate engine drains both FIFOs.

The input uses a valid/ready handshake. A separate end-of-matrix beat flushes the last pending count. Both FIFOs are synchronous and first-word-fall-through, and each has its own pop and empty signals. A stall output rises whenever either FIFO is full, and no input is taken while it is high. Rows with no non-zero entries produce no count.

Top module: `sprow_run_counter`

## Requirements
- R1: After reset both FIFOs are empty, `stall` is low and `in_ready` is high.
- R2: Every accepted coordinate beat (`in_eom`=0) pushes its column field, `in_coord[5:0]` with defaults, into the column FIFO. The column FIFO returns these fields in arrival order.
- R3: A coordinate beat whose row field, `in_coord[11:6]`, equals that of the previous accepted coordinate adds one to the running count and pushes nothing into the row-count FIFO.
- R4: A coordinate beat whose row field differs from the previous one pushes the finished count into the row-count FIFO, as an unsigned binary number, and restarts the count at one.
- R5: The first coordinate beat after reset, or after an end-of-matrix beat, starts a count of one and pushes no row count.
- R6: An accepted beat with `in_eom`=1 ignores `in_coord`. It pushes the pending count, if any, into the row-count FIFO and pushes nothing into the column FIFO. When no count is pending, it pushes nothing at all.
- R7: `stall` is high exactly when either FIFO holds DEPTH entries. `in_ready` is the inverse of `stall`, and a beat offered while stalled is ignored.
- R8: Each FIFO shows its oldest entry on its data output whenever its empty flag is low. A pop removes that entry. A pop while empty has no effect.
- R9: Counts are CNT_W bits wide (default 7), so a row that holds all 64 columns is recorded as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_eom | input | 1 | Beat is an end-of-matrix marker, not a coordinate |
| in_coord | input | ROW_W+COL_W | Row index (upper) and column index (lower) |
| in_ready | output | 1 | Beat is accepted when high together with in_valid |
| stall | output | 1 | Either metadata FIFO is full |
| col_pop | input | 1 | Remove head of column FIFO |
| col_empty | output | 1 | Column FIFO empty |
| col_data | output | COL_W | Head of column FIFO |
| cnt_pop | input | 1 | Remove head of row-count FIFO |
| cnt_empty | output | 1 | Row-count FIFO empty |
| cnt_data | output | CNT_W | Head of row-count FIFO |

## Verification
The bench builds the block with a FIFO depth of 4 and default 6-bit row and column fields, with 7-bit counts. The shallow depth means a few beats fill the column FIFO, and a run of short rows fills the row-count FIFO. Both stall causes, and the ignoring of a beat offered during a stall, can therefore be reached in a short run. The full 6-bit column range still allows a complete 64-element row to exercise the widest count.

// File: rtl/sprc_pkg.sv
// Shared definitions for the sparse row index run counter.
// Assumes nothing beyond the parameters of the modules that import it.
package sprc_pkg;
    // Kind of an accepted input beat.
    typedef enum logic {
        BEAT_COORD = 1'b0,
        BEAT_EOM   = 1'b1
    } beat_kind_e;
endpackage

// File: rtl/sprc_fifo.sv
// Synchronous first-word-fall-through FIFO.
// The head entry is presented combinationally whenever empty is low.
// Assumes the writer never pushes while full. A pop while empty is ignored.
module sprc_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [OW-1:0] occ;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (occ == '0);
    assign full    = (occ == OW'(DEPTH));
    assign head    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/sprc_run_tracker.sv
// Row run tracker: compares each accepted row index with the previous one.
// It counts elements of the current row and emits the finished count on a row change
// or on an end-of-matrix beat.
// Assumes take is only raised for beats actually accepted, and that no row holds
// more than 2**CNT_W-1 elements.
module sprc_run_tracker
    import sprc_pkg::*;
#(
    parameter int ROW_W = 6,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  beat_kind_e       kind,
    input  logic [ROW_W-1:0] row,
    output logic             emit,
    output logic [CNT_W-1:0] emit_cnt
);
    logic             have_row;
    logic [ROW_W-1:0] cur_row;
    logic [CNT_W-1:0] cur_cnt;
    logic             row_change;

    assign row_change = have_row && (row != cur_row);
    assign emit_cnt   = cur_cnt;

    // Decide whether the accepted beat closes a row.
    always_comb begin
        emit = 1'b0;
        if (take) begin
            if (kind == BEAT_EOM) emit = have_row;
            else                  emit = row_change;
        end
    end

    // Track the current row and its running count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_row <= 1'b0;
            cur_row  <= '0;
            cur_cnt  <= '0;
        end else if (take) begin
            if (kind == BEAT_EOM) begin
                have_row <= 1'b0;
                cur_cnt  <= '0;
            end else if (have_row && !row_change) begin
                cur_cnt  <= cur_cnt + 1'b1;
            end else begin
                have_row <= 1'b1;
                cur_row  <= row;
                cur_cnt  <= CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sprow_run_counter.sv
// Sparse row index run counter: converts a row-major stream of packed coordinates
// into a column-index FIFO and a per-row count FIFO (compressed-row metadata).
// Assumes coordinates of one row arrive contiguously. Backpressure is raised while
// either FIFO is full.
module sprow_run_counter
    import sprc_pkg::*;
#(
    parameter int ROW_W = 6,
    parameter int COL_W = 6,
    parameter int CNT_W = 7,
    parameter int DEPTH = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_eom,
    input  logic [ROW_W+COL_W-1:0] in_coord,
    output logic                   in_ready,
    output logic                   stall,
    input  logic                   col_pop,
    output logic                   col_empty,
    output logic [COL_W-1:0]       col_data,
    input  logic                   cnt_pop,
    output logic                   cnt_empty,
    output logic [CNT_W-1:0]       cnt_data
);
    localparam int CW = ROW_W + COL_W;

    logic             accept;
    logic             col_full, cnt_full;
    logic             cnt_push;
    logic [CNT_W-1:0] cnt_value;
    beat_kind_e       kind;

    assign stall    = col_full || cnt_full;
    assign in_ready = !stall;
    assign accept   = in_valid && in_ready;
    assign kind     = in_eom ? BEAT_EOM : BEAT_COORD;

    sprc_run_tracker #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (accept),
        .kind     (kind),
        .row      (in_coord[CW-1:COL_W]),
        .emit     (cnt_push),
        .emit_cnt (cnt_value)
    );

    sprc_fifo #(.W(COL_W), .DEPTH(DEPTH)) u_col_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept && !in_eom),
        .push_data (in_coord[COL_W-1:0]),
        .pop       (col_pop),
        .head      (col_data),
        .empty     (col_empty),
        .full      (col_full)
    );

    sprc_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_cnt_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cnt_push),
        .push_data (cnt_value),
        .pop       (cnt_pop),
        .head      (cnt_data),
        .empty     (cnt_empty),
        .full      (cnt_full)
    );
endmodule

// File: rtl/sprow_run_counter_chk.sv
// Port-level checker for the sparse row index run counter, bound to the top.
// It keeps its own model of column FIFO occupancy and of the last accepted row.
module sprow_run_counter_chk #(
    parameter int ROW_W = 6,
    parameter int DEPTH = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_eom,
    input logic [ROW_W-1:0] coord_row,
    input logic             in_ready,
    input logic             col_pop,
    input logic             col_empty,
    input logic             cnt_pop,
    input logic             cnt_empty
);
    localparam int OW = $clog2(DEPTH + 1) + 1;

    logic             acc, acc_coord;
    logic [OW-1:0]    occ;
    logic             have;
    logic [ROW_W-1:0] last_row;

    assign acc       = in_valid && in_ready;
    assign acc_coord = acc && !in_eom;

    // Model column FIFO occupancy and the previous accepted row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ      <= '0;
            have     <= 1'b0;
            last_row <= '0;
        end else begin
            occ <= occ + OW'(acc_coord) - OW'(col_pop && !col_empty);
            if (acc && in_eom) have <= 1'b0;
            else if (acc_coord) begin
                have     <= 1'b1;
                last_row <= coord_row;
            end
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(DEPTH));

    p_col_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        col_empty == (occ == '0));

    p_same_row_no_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_coord && have && coord_row == last_row && cnt_empty) |=> cnt_empty);

    p_row_change_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_coord && have && coord_row != last_row) |=> !cnt_empty);

    p_eom_no_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_eom && !col_pop) |=> $stable(col_empty));

    p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pop && cnt_empty && !acc) |=> cnt_empty);
endmodule

bind sprow_run_counter sprow_run_counter_chk #(.ROW_W(ROW_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_eom    (in_eom),
    .coord_row (in_coord[ROW_W+COL_W-1:COL_W]),
    .in_ready  (in_ready),
    .col_pop   (col_pop),
    .col_empty (col_empty),
    .cnt_pop   (cnt_pop),
    .cnt_empty (cnt_empty)
);

// File: tb/tb_sprow_run_counter.sv
`timescale 1ns/1ps
module tb_sprow_run_counter;
    localparam int ROW_W = 6;
    localparam int COL_W = 6;
    localparam int CNT_W = 7;
    localparam int DEPTH = 4;
    localparam int NTBL  = 10;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_eom = 1'b0;
    logic [ROW_W+COL_W-1:0] in_coord = '0;
    logic                   in_ready, stall;
    logic                   col_pop = 1'b0, col_empty;
    logic [COL_W-1:0]       col_data;
    logic                   cnt_pop = 1'b0, cnt_empty;
    logic [CNT_W-1:0]       cnt_data;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    sprow_run_counter #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eom(in_eom), .in_coord(in_coord),
        .in_ready(in_ready), .stall(stall),
        .col_pop(col_pop), .col_empty(col_empty), .col_data(col_data),
        .cnt_pop(cnt_pop), .cnt_empty(cnt_empty), .cnt_data(cnt_data)
    );

    // Table entry: {eom, row[6], col[6], count expected, expected count[7]}.
    localparam logic [20:0] TBL [NTBL] = '{
        {1'b0, 6'd1, 6'd3,  1'b0, 7'd0},  // R5 first coordinate
        {1'b0, 6'd1, 6'd7,  1'b0, 7'd0},  // R3 same row
        {1'b0, 6'd1, 6'd0,  1'b0, 7'd0},  // R3 same row
        {1'b0, 6'd4, 6'd2,  1'b1, 7'd3},  // R4 row change
        {1'b0, 6'd5, 6'd63, 1'b1, 7'd1},  // R4 single-element row
        {1'b1, 6'd0, 6'd0,  1'b1, 7'd1},  // R6 flush pending
        {1'b1, 6'd9, 6'd9,  1'b0, 7'd0},  // R6 nothing pending
        {1'b0, 6'd2, 6'd5,  1'b0, 7'd0},  // R5 first after flush
        {1'b0, 6'd2, 6'd6,  1'b0, 7'd0},  // R3
        {1'b1, 6'd7, 6'd44, 1'b1, 7'd2}   // R6 coord field ignored
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One accepted-beat slot: drive for one rising edge, then release.
    task automatic beat(input bit eom, input int row, input int col);
        @(negedge clk);
        in_valid = 1'b1;
        in_eom   = eom;
        in_coord = {ROW_W'(row), COL_W'(col)};
        @(negedge clk);
        in_valid = 1'b0;
        in_eom   = 1'b0;
    endtask

    task automatic pop(input bit c, input bit n);
        col_pop = c;
        cnt_pop = n;
        @(negedge clk);
        col_pop = 1'b0;
        cnt_pop = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 col_empty", col_empty, 1);
        check("R1 cnt_empty", cnt_empty, 1);
        check("R1 stall", stall, 0);
        check("R1 in_ready", in_ready, 1);

        // Table walk: one beat, then inspect and drain both FIFO heads.
        for (int i = 0; i < NTBL; i++) begin
            automatic logic [20:0] e = TBL[i];
            beat(e[20], int'(e[19:14]), int'(e[13:8]));
            if (e[20]) check("R6 no column push on eom", col_empty, 1);
            else begin
                check("R2 column present", col_empty, 0);
                check("R2 column value", col_data, int'(e[13:8]));
            end
            check("R3/R4/R5/R6 count presence", !cnt_empty, int'(e[7]));
            if (e[7]) check("R4/R6 count value", cnt_data, int'(e[6:0]));
            pop(!col_empty, !cnt_empty);
        end

        // R8: pops on empty FIFOs have no effect.
        pop(1'b1, 1'b1);
        check("R8 col stays empty", col_empty, 1);
        check("R8 cnt stays empty", cnt_empty, 1);
        beat(1'b0, 9, 11);
        check("R8 head after empty pop", col_data, 11);
        pop(1'b1, 1'b0);
        beat(1'b1, 0, 0);
        check("R8 count head", cnt_data, 1);
        pop(1'b0, 1'b1);

        // R7: fill column FIFO, offer a beat while stalled.
        for (int k = 0; k < DEPTH; k++) beat(1'b0, 3, 20 + k);
        check("R7 stall on column full", stall, 1);
        check("R7 in_ready low", in_ready, 0);
        @(negedge clk);
        in_valid = 1'b1; in_coord = {6'd8, 6'd9};
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        check("R7 stalled beat ignored (no count)", cnt_empty, 1);
        for (int k = 0; k < DEPTH; k++) begin
            check("R2/R7 column order", col_data, 20 + k);
            pop(1'b1, 1'b0);
        end
        check("R7 stalled beat ignored (no column)", col_empty, 1);
        check("R7 stall released", stall, 0);
        beat(1'b1, 0, 0);
        check("R7 count excludes stalled beat", cnt_data, DEPTH);
        pop(1'b0, 1'b1);

        // R7: fill the row-count FIFO with single-element rows.
        for (int k = 0; k <= DEPTH; k++) begin
            beat(1'b0, 30 + k, k);
            pop(1'b1, 1'b0);
        end
        check("R7 stall on count full", stall, 1);
        for (int k = 0; k < DEPTH; k++) begin
            check("R4 single row count", cnt_data, 1);
            pop(1'b0, 1'b1);
        end
        check("R7 stall released after count drain", stall, 0);
        beat(1'b1, 0, 0);
        check("R6 final flush", cnt_data, 1);
        pop(1'b0, 1'b1);

        // R9: a full 64-element row.
        for (int k = 0; k < 64; k++) begin
            beat(1'b0, 10, k);
            pop(1'b1, 1'b0);
        end
        check("R9 no count before flush", cnt_empty, 1);
        beat(1'b1, 0, 0);
        check("R9 full row count", cnt_data, 64);
        pop(1'b0, 1'b1);
        check("R8 count FIFO drained", cnt_empty, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule